// File: doc/BRIEF.md
# Local Interrupt Timer with Vector-Table Entry

A per-core down-counting timer whose expiry is handled by one packed 32-bit vector-table entry. Software writes the entry and then an initial count. The initial-count write loads the live counter and arms it. Each cycle with `tick_en` high takes one count off. When the counter steps from 1 to 0, the block consults the entry:

- If the entry's mask bit is clear, a one-cycle request leaves the block. It carries the entry's vector, delivery mode and trigger level.
- If the periodic bit is set, the initial count is written back into the counter, so the countdown restarts on its own. This reload happens even while the request is masked.

The request is a fire-and-forget pulse with no ready input and no back-pressure. The downstream delivery logic must take it in the cycle it appears. No other port of the block is a data stream. The register port is plain: writes are accepted every cycle, and reads are combinational.

Register addresses on `wr_addr` / `rd_addr`:

| Address | Register | Access |
|---------|----------|--------|
| 0 | entry | read/write |
| 1 | initial count | read/write |
| 2 | current count | read-only |
| 3 | unused | reads zero |

Top module: `lvt_timer_top`

## Requirements
- R1: After reset, the entry, the initial count and the current count are zero. Every address reads zero and `req_valid` is low.
- R2: The entry fields sit at these bits:
  - vector: bits 7:0
  - delivery mode: bits 10:8
  - delivery status: bit 12
  - polarity: bit 13
  - remote-request flag: bit 14
  - trigger level: bit 15
  - mask: bit 16
  - periodic: bit 17

  Address 0 reads back the whole written word.
- R3: A write to address 1 stores the initial count and loads the same value into the current count on the next edge. Writing zero stops the timer, and it then raises no request.
- R4: The current count drops by exactly one on each edge where `tick_en` is high and the count is nonzero. It holds its value when `tick_en` is low.
- R5: Expiry is the tick on which the count goes from 1 to 0. In one-shot mode (bit 17 clear) the count then stays at zero, and no further request follows.
- R6: An unmasked expiry gives `req_valid` high for one cycle, starting on the edge of the expiry tick. In that cycle `req_vector`, `req_mode` and `req_level` equal entry bits 7:0, 10:8 and 15. Outside a pulse these fields are zero.
- R7: An expiry with the mask bit (16) set raises no request.
- R8: With the periodic bit (17) set, expiry reloads the current count from the initial count. This applies whether or not the mask bit is set.
- R9: The current count (address 2) is read-only, and writes to address 2 change nothing. Address 3 reads zero.
- R10: An initial-count write in the same cycle as a tick wins. The count takes the written value, and no expiry or request comes from that tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 entry, 1 initial count, 2 current count) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address, same map, 3 reads zero |
| rd_data | output | 32 | Combinational read data |
| tick_en | input | 1 | Count enable, one decrement per high cycle |
| req_valid | output | 1 | One-cycle interrupt request pulse |
| req_vector | output | 8 | Vector of the request |
| req_mode | output | 3 | Delivery mode of the request |
| req_level | output | 1 | Trigger level of the request (1 level, 0 edge) |

## Verification
The timer is run in four configurations, each combining one-shot or periodic mode with masked or unmasked requests. Pulse counts over fixed tick windows separate a correct reload from a missing one, and separate a masked expiry from a leaking one. Directed cases cover three further situations:
- a zero write that stops the timer;
- a write to the read-only counter;
- an initial-count write landing on the same cycle as an expiry tick.

These cases expose write/tick priority mistakes. A long run with a pseudo-random tick pattern and entry rewrites in mid-count is compared cycle by cycle with a behavioural model. It catches off-by-one expiry timing, and fields taken from a stale entry.

// File: rtl/lvt_timer_pkg.sv
package lvt_timer_pkg;

  localparam int ENTRY_W = 32;
  localparam int ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] A_ENTRY = 2'd0;
  localparam logic [ADDR_W-1:0] A_INIT  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CUR   = 2'd2;

  typedef struct packed {
    logic [13:0] spare;
    logic        periodic;
    logic        masked;
    logic        level_trig;
    logic        remote_flag;
    logic        pin_pol;
    logic        dlv_status;
    logic        gap11;
    logic [2:0]  dlv_mode;
    logic [7:0]  vector;
  } lvt_entry_t;

endpackage

// File: rtl/lvt_cfg_regs.sv
module lvt_cfg_regs
  import lvt_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [ENTRY_W-1:0]   wr_data,
  output lvt_entry_t           entry,
  output logic [CNT_W-1:0]     init_cnt,
  output logic                 load
);

  logic entry_we;

  assign entry_we = wr_en && (wr_addr == A_ENTRY);
  assign load     = wr_en && (wr_addr == A_INIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry    <= '0;
      init_cnt <= '0;
    end else begin
      if (entry_we) entry <= lvt_entry_t'(wr_data);
      if (load)     init_cnt <= wr_data[CNT_W-1:0];
    end
  end

  AST_INIT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> init_cnt == $past(wr_data[CNT_W-1:0])); // R3

  AST_ENTRY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !entry_we |=> $stable(entry)); // R2

endmodule

// File: rtl/lvt_down_counter.sv
module lvt_down_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             periodic,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cur,
  output logic             expire
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic running;

  assign running = cur != '0;
  assign expire  = tick && !load && (cur == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0;
    end else if (load) begin
      cur <= load_val;
    end else if (tick && running) begin
      if (cur == ONE) cur <= periodic ? reload_val : '0;
      else            cur <= cur - ONE;
    end
  end

  AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cur > ONE) |=> cur == $past(cur) - ONE); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cur)); // R4

  AST_ONESHOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !periodic) |=> cur == '0); // R5

  AST_PERIOD_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && periodic) |=> cur == $past(reload_val)); // R8

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cur == $past(load_val)); // R10

endmodule

// File: rtl/lvt_req_gen.sv
module lvt_req_gen
  import lvt_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       expire,
  input  lvt_entry_t entry,
  output logic       req_valid,
  output logic [7:0] req_vector,
  output logic [2:0] req_mode,
  output logic       req_level
);

  logic fire;

  assign fire = expire && !entry.masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid  <= 1'b0;
      req_vector <= '0;
      req_mode   <= '0;
      req_level  <= 1'b0;
    end else begin
      req_valid  <= fire;
      req_vector <= fire ? entry.vector     : '0;
      req_mode   <= fire ? entry.dlv_mode   : '0;
      req_level  <= fire ? entry.level_trig : 1'b0;
    end
  end

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && entry.masked) |=> !req_valid); // R7

  AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(expire)); // R6

  AST_REQ_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !entry.masked) |=> (req_valid && req_vector == $past(entry.vector)
                                   && req_mode == $past(entry.dlv_mode))); // R6

endmodule

// File: rtl/lvt_timer_top.sv
module lvt_timer_top
  import lvt_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  input  logic        tick_en,
  output logic        req_valid,
  output logic [7:0]  req_vector,
  output logic [2:0]  req_mode,
  output logic        req_level
);

  lvt_entry_t       entry;
  logic [CNT_W-1:0] init_cnt;
  logic [CNT_W-1:0] cur;
  logic             load;
  logic             expire;

  lvt_cfg_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .entry    (entry),
    .init_cnt (init_cnt),
    .load     (load)
  );

  lvt_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .load_val   (wr_data[CNT_W-1:0]),
    .tick       (tick_en),
    .periodic   (entry.periodic),
    .reload_val (init_cnt),
    .cur        (cur),
    .expire     (expire)
  );

  lvt_req_gen u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .expire     (expire),
    .entry      (entry),
    .req_valid  (req_valid),
    .req_vector (req_vector),
    .req_mode   (req_mode),
    .req_level  (req_level)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_ENTRY: rd_data = entry;
      A_INIT:  rd_data[CNT_W-1:0] = init_cnt;
      A_CUR:   rd_data[CNT_W-1:0] = cur;
      default: rd_data = '0;
    endcase
  end

  AST_CUR_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CUR && !tick_en) |=> $stable(cur)); // R9

endmodule

// File: tb/lvt_timer_top_bench.sv
module lvt_timer_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = 2'd2;
  logic        tick_en = 1'b0;
  logic [31:0] rd_data;
  logic        req_valid;
  logic [7:0]  req_vector;
  logic [2:0]  req_mode;
  logic        req_level;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 1'b0;

  logic [31:0] m_entry = '0, m_init = '0, m_cur = '0;
  logic        m_req = 1'b0, m_lvl = 1'b0;
  logic [7:0]  m_vec = '0;
  logic [2:0]  m_mode = '0;

  lvt_timer_top u_lvt_timer_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tick_en(tick_en), .req_valid(req_valid),
    .req_vector(req_vector), .req_mode(req_mode), .req_level(req_level)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return m_entry;
      2'd1: return m_init;
      2'd2: return m_cur;
      default: return 32'h0;
    endcase
  endfunction

  // behavioural reference model
  always @(posedge clk) begin
    if (rst_n) begin
      automatic bit ld  = wr_en && wr_addr == 2'd1;
      automatic bit exp = tick_en && !ld && m_cur == 32'd1;
      m_req  = exp && !m_entry[16];
      m_vec  = m_req ? m_entry[7:0]  : 8'h0;
      m_mode = m_req ? m_entry[10:8] : 3'h0;
      m_lvl  = m_req ? m_entry[15]   : 1'b0;
      if (ld) m_cur = wr_data;
      else if (tick_en && m_cur != 0) begin
        if (m_cur == 1) m_cur = m_entry[17] ? m_init : 32'h0;
        else m_cur = m_cur - 1;
      end
      if (ld) m_init = wr_data;
      if (wr_en && wr_addr == 2'd0) m_entry = wr_data;
    end
  end

  // cycle-by-cycle comparison
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      chk("R6/R7 req_valid", 32'(req_valid), 32'(m_req));
      chk("R6 req_vector", 32'(req_vector), 32'(m_vec));
      chk("R6 req_mode", 32'(req_mode), 32'(m_mode));
      chk("R6 req_level", 32'(req_level), 32'(m_lvl));
      chk("R4 rd_data", rd_data, m_read(rd_addr));
      if (req_valid) pulses++;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
    rd_addr = a;
    #1;
    chk(tag, rd_data, exp);
    rd_addr = 2'd2;
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int p0;
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd_chk(2'd0, 32'h0, "R1 entry after reset");
    rd_chk(2'd1, 32'h0, "R1 init after reset");
    rd_chk(2'd2, 32'h0, "R1 cur after reset");
    chk("R1 req_valid after reset", 32'(req_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 readback, R3 load, R5/R6 one-shot unmasked
    wr(2'd0, 32'h0000_83A5);
    rd_chk(2'd0, 32'h0000_83A5, "R2 entry readback");
    wr(2'd1, 32'd5);
    rd_chk(2'd1, 32'd5, "R3 init stored");
    rd_chk(2'd2, 32'd5, "R3 cur loaded");
    p0 = pulses;
    ticks(4);
    chk("R5 no early expiry", 32'(req_valid), 32'h0);
    ticks(1);
    chk("R6 pulse on expiry", 32'(req_valid), 32'h1);
    chk("R6 vector", 32'(req_vector), 32'hA5);
    chk("R6 mode", 32'(req_mode), 32'h3);
    chk("R6 level", 32'(req_level), 32'h1);
    rd_chk(2'd2, 32'h0, "R5 count at zero");
    ticks(3);
    rd_chk(2'd2, 32'h0, "R5 one-shot stays zero");
    chk("R5 single pulse", 32'(pulses - p0), 32'd1);

    // R7 masked one-shot
    wr(2'd0, 32'h0001_0042);
    wr(2'd1, 32'd3);
    p0 = pulses;
    ticks(6);
    chk("R7 masked no pulse", 32'(pulses - p0), 32'd0);
    rd_chk(2'd2, 32'h0, "R7 count expired");

    // R8 periodic unmasked
    wr(2'd0, 32'h0002_0110);
    wr(2'd1, 32'd4);
    p0 = pulses;
    ticks(20);
    chk("R8 periodic pulse count", 32'(pulses - p0), 32'd5);
    rd_chk(2'd2, 32'd4, "R8 reload value");

    // R8 periodic masked still reloads
    wr(2'd0, 32'h0003_0077);
    wr(2'd1, 32'd3);
    p0 = pulses;
    ticks(7);
    rd_chk(2'd2, 32'd2, "R8 masked reload");
    chk("R7 periodic masked no pulse", 32'(pulses - p0), 32'd0);

    // R4 hold without tick
    wr(2'd0, 32'h0000_0020);
    wr(2'd1, 32'd6);
    repeat (5) @(negedge clk);
    rd_chk(2'd2, 32'd6, "R4 hold without tick");
    ticks(2);
    rd_chk(2'd2, 32'd4, "R4 decrement per tick");

    // R3 zero write stops
    wr(2'd1, 32'd10);
    ticks(3);
    rd_chk(2'd2, 32'd7, "R4 partial count");
    wr(2'd1, 32'd0);
    rd_chk(2'd2, 32'd0, "R3 zero write stops");
    p0 = pulses;
    ticks(5);
    rd_chk(2'd2, 32'd0, "R3 stopped stays zero");
    chk("R3 stopped no pulse", 32'(pulses - p0), 32'd0);

    // R9 read-only current count
    wr(2'd1, 32'd9);
    wr(2'd2, 32'h0000_DEAD);
    rd_chk(2'd2, 32'd9, "R9 cur unchanged by write");
    rd_chk(2'd1, 32'd9, "R9 init unchanged by write");
    rd_chk(2'd3, 32'h0, "R9 unused address reads zero");

    // R10 write on expiry tick
    ticks(8);
    rd_chk(2'd2, 32'd1, "R10 setup");
    p0 = pulses;
    tick_en = 1'b1;
    wr(2'd1, 32'd12);
    tick_en = 1'b0;
    rd_chk(2'd2, 32'd12, "R10 write wins");
    chk("R10 no request", 32'(req_valid), 32'h0);
    chk("R10 no pulse", 32'(pulses - p0), 32'd0);

    // irregular ticks with entry rewrites, model compared each clock
    wr(2'd0, 32'h0002_80C3);
    wr(2'd1, 32'd3);
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      tick_en = lfsr[0] | lfsr[3];
      if (i % 37 == 5) begin
        wr_en = 1'b1; wr_addr = 2'd0;
        wr_data = {14'h0, 1'b1, lfsr[7], lfsr[8], 5'h0, lfsr[11:9], lfsr[15:8]};
      end else if (i % 53 == 7) begin
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = {29'h0, lfsr[6:4]};
      end
      @(negedge clk);
      wr_en = 1'b0;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
    tick_en = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule